// File: doc/BRIEF.md
# Flash Command Sequencer

This block is the command front end of a word-wide NOR flash model. It watches host write cycles, each a one-clock strobe with an address and a 16-bit data word. It follows the multi-write unlock handshakes that guard every program, erase and mode change. When a handshake completes, it issues a one-clock start pulse to the array engine and latches the target address and data for the engine to use. It also keeps the current read mode, which tells the read path whether to return array contents, identification codes, query table data or the security area.

The write-protect input and a busy input from the array engine gate what gets through. While the engine is working, writes are ignored, apart from a suspend request. With protection active, any program or erase aimed at the protected boot block is dropped. Array storage, operation timing and status bits are handled elsewhere.

Top module: `flash_cmd_seq`

## Requirements
- R1: A synchronous active-low reset sets the read mode to array (code 0) and clears all start pulses within one clock. It also empties the sequence, so any partly entered handshake is forgotten.
- R2: Writes of AAh at 5555h, 55h at 2AAAh and A0h at 5555h arm a program. The next write of any address and data raises `prog_start` for one cycle, the clock after that write. On the same clock, `op_addr` and `op_data` hold that write's address and data.
- R3: Writes of AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h and 55h@2AAAh, followed by a sixth write, select an erase. A sixth write of 30h at any address pulses `sect_erase_start`. 50h at any address pulses `blk_erase_start`. 10h at 5555h pulses `chip_erase_start`. `op_addr` holds the sixth write's address.
- R4: After the two unlock writes, a third write at 5555h sets the read mode: 90h selects ID (code 1), 98h selects query (code 2) and 88h selects security ID (code 3). F0h at that point returns to array (code 0), and so does a single F0h write at any address from idle.
- R5: From idle, a single write of B0h at any address pulses `suspend_req`, and a single 30h write pulses `resume_req`. A B0h write from idle is accepted even while `busy` is high.
- R6: A write that does not match the expected step partway through a handshake aborts it. The read mode returns to array, no pulse is issued, and a new handshake must start from the first write.
- R7: Command matching looks only at address bits 14:0 and data bits 7:0. The upper address and data bits may hold any value during a handshake.
- R8: While `busy` is high, every write except a B0h write from idle is ignored. Such writes issue no pulse and leave the read mode unchanged, including F0h exit writes.
- R9: With `wp_n` low, a program, sector erase or block erase whose address lies in the boot block is dropped, and so is any chip erase. The boot block is the set of addresses whose bits above bit BLK_LSB-1 are all zero, or all one when BOOT_TOP=1. With `wp_n` high, all of these operations are accepted.
- R10: In ID mode, `id_data` gives 00BFh at read address 0, DEV_CODE at read address 1, and 0 at any other address. Outside ID mode `id_data` is 0.
- R11: Each start or request pulse lasts exactly one clock. It appears only on the clock after an accepted write, and at most one pulse is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-clock host write strobe |
| wr_addr | input | ADDR_W | Host write word address |
| wr_data | input | 16 | Host write data |
| rd_addr | input | ADDR_W | Read address for the identification codes |
| busy | input | 1 | Array engine is running a program or erase |
| wp_n | input | 1 | Write protect, active low, guards the boot block |
| prog_start | output | 1 | Word program start pulse |
| sect_erase_start | output | 1 | Sector erase start pulse |
| blk_erase_start | output | 1 | Block erase start pulse |
| chip_erase_start | output | 1 | Chip erase start pulse |
| suspend_req | output | 1 | Erase suspend request pulse |
| resume_req | output | 1 | Erase resume request pulse |
| op_addr | output | ADDR_W | Address latched with the last start pulse |
| op_data | output | 16 | Data latched with the last start pulse |
| read_mode | output | 2 | 0 array, 1 ID, 2 query, 3 security ID |
| id_data | output | 16 | Identification word for rd_addr in ID mode |

## Verification
A wrong sequence state shows up in the pulses on the write that finishes a handshake. It also shows up on the clock after an abort, because `read_mode` is registered and visible one clock after each write. The bench therefore drives every possible data byte into the third and sixth handshake steps and compares pulse and mode on that same clock. A handshake state stuck after an abort or a reset shows as a missing or extra start pulse on the very next handshake. Write-protect and busy gating errors show as pulses that should not appear on the clock after the gated write.

// File: rtl/flash_cmd_pkg.sv
// Package: shared encodings for the flash command sequencer.
// Assumes the command address compare uses 15 bits and the command data compare uses 8 bits.
package flash_cmd_pkg;
    localparam int CMD_AW = 15;
    localparam int CMD_DW = 8;

    localparam logic [CMD_AW-1:0] KEY_ADDR_A = 15'h5555;
    localparam logic [CMD_AW-1:0] KEY_ADDR_B = 15'h2AAA;

    localparam logic [CMD_DW-1:0] C_KEY1    = 8'hAA;
    localparam logic [CMD_DW-1:0] C_KEY2    = 8'h55;
    localparam logic [CMD_DW-1:0] C_PROG    = 8'hA0;
    localparam logic [CMD_DW-1:0] C_ERASE   = 8'h80;
    localparam logic [CMD_DW-1:0] C_IDENT   = 8'h90;
    localparam logic [CMD_DW-1:0] C_QUERY   = 8'h98;
    localparam logic [CMD_DW-1:0] C_SECID   = 8'h88;
    localparam logic [CMD_DW-1:0] C_EXIT    = 8'hF0;
    localparam logic [CMD_DW-1:0] C_SUSPEND = 8'hB0;
    localparam logic [CMD_DW-1:0] C_SECTOR  = 8'h30;
    localparam logic [CMD_DW-1:0] C_BLOCK   = 8'h50;
    localparam logic [CMD_DW-1:0] C_CHIP    = 8'h10;

    localparam logic [15:0] MFR_CODE = 16'h00BF;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PROG, SQ_ERA3, SQ_ERA4, SQ_ERA5
    } seq_t;

    typedef enum logic [1:0] {
        RM_ARRAY = 2'd0, RM_ID = 2'd1, RM_CFI = 2'd2, RM_SECID = 2'd3
    } rmode_t;

    typedef enum logic [2:0] {
        OP_NONE, OP_PROG, OP_SECT, OP_BLK, OP_CHIP, OP_SUSP, OP_RES
    } op_t;

    typedef struct packed {
        logic at_a;
        logic at_b;
        logic d_key1;
        logic d_key2;
        logic d_prog;
        logic d_erase;
        logic d_ident;
        logic d_query;
        logic d_secid;
        logic d_exit;
        logic d_susp;
        logic d_sector;
        logic d_block;
        logic d_chip;
    } match_t;
endpackage

// File: rtl/flash_cmd_decode.sv
// Module: flash_cmd_decode
// Compares the low address and data bits of a host write against the fixed
// command keys. Purely combinational; assumes the caller slices the low bits.
module flash_cmd_decode
    import flash_cmd_pkg::*;
(
    input  logic [CMD_AW-1:0] low_addr,
    input  logic [CMD_DW-1:0] low_data,
    output match_t            hit
);
    // Key comparison: one flag per address key and per command code.
    always_comb begin
        hit.at_a     = (low_addr == KEY_ADDR_A);
        hit.at_b     = (low_addr == KEY_ADDR_B);
        hit.d_key1   = (low_data == C_KEY1);
        hit.d_key2   = (low_data == C_KEY2);
        hit.d_prog   = (low_data == C_PROG);
        hit.d_erase  = (low_data == C_ERASE);
        hit.d_ident  = (low_data == C_IDENT);
        hit.d_query  = (low_data == C_QUERY);
        hit.d_secid  = (low_data == C_SECID);
        hit.d_exit   = (low_data == C_EXIT);
        hit.d_susp   = (low_data == C_SUSPEND);
        hit.d_sector = (low_data == C_SECTOR);
        hit.d_block  = (low_data == C_BLOCK);
        hit.d_chip   = (low_data == C_CHIP);
    end
endmodule

// File: rtl/flash_boot_guard.sv
// Module: flash_boot_guard
// Flags whether a block index names the protected boot block. BOOT_TOP picks
// the highest block (1) or the lowest block (0). Combinational.
module flash_boot_guard #(
    parameter int IDX_W    = 7,
    parameter bit BOOT_TOP = 1'b0
) (
    input  logic [IDX_W-1:0] blk_idx,
    output logic             in_boot
);
    generate
        if (BOOT_TOP) begin : g_top
            // Top boot block: all index bits set.
            assign in_boot = &blk_idx;
        end else begin : g_bottom
            // Bottom boot block: all index bits clear.
            assign in_boot = ~|blk_idx;
        end
    endgenerate
endmodule

// File: rtl/flash_cmd_fsm.sv
// Module: flash_cmd_fsm
// Walks the unlock handshakes, keeps the read mode and issues one-clock
// operation pulses. Assumes wr_en is a single-clock strobe per host write and
// that in_boot describes the current wr_addr.
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  match_t            hit,
    input  logic              in_boot,
    input  logic              busy,
    input  logic              wp_n,
    output logic              prog_start,
    output logic              sect_erase_start,
    output logic              blk_erase_start,
    output logic              chip_erase_start,
    output logic              suspend_req,
    output logic              resume_req,
    output logic [ADDR_W-1:0] op_addr,
    output logic [15:0]       op_data,
    output rmode_t            read_mode
);
    seq_t   sq_q, sq_n;
    rmode_t rm_n;
    op_t    op_q, op_n;
    logic   guarded;

    // Protection applies only while wp_n is low and the target is the boot block.
    assign guarded = in_boot && !wp_n;

    // Next-state logic: handshake step, read mode and the operation to launch.
    always_comb begin
        sq_n = sq_q;
        rm_n = read_mode;
        op_n = OP_NONE;
        if (wr_en) begin
            if (busy) begin
                if (sq_q == SQ_IDLE && hit.d_susp) op_n = OP_SUSP;
            end else begin
                unique case (sq_q)
                    SQ_IDLE: begin
                        if (hit.at_a && hit.d_key1) sq_n = SQ_UNL1;
                        else if (hit.d_exit)        rm_n = RM_ARRAY;
                        else if (hit.d_susp)        op_n = OP_SUSP;
                        else if (hit.d_sector)      op_n = OP_RES;
                    end
                    SQ_UNL1: begin
                        if (hit.at_b && hit.d_key2) sq_n = SQ_UNL2;
                        else begin sq_n = SQ_IDLE; rm_n = RM_ARRAY; end
                    end
                    SQ_UNL2: begin
                        sq_n = SQ_IDLE;
                        if (!hit.at_a)          rm_n = RM_ARRAY;
                        else if (hit.d_prog)    sq_n = SQ_PROG;
                        else if (hit.d_erase)   sq_n = SQ_ERA3;
                        else if (hit.d_ident)   rm_n = RM_ID;
                        else if (hit.d_query)   rm_n = RM_CFI;
                        else if (hit.d_secid)   rm_n = RM_SECID;
                        else                    rm_n = RM_ARRAY;
                    end
                    SQ_PROG: begin
                        sq_n = SQ_IDLE;
                        if (!guarded) op_n = OP_PROG;
                    end
                    SQ_ERA3: begin
                        if (hit.at_a && hit.d_key1) sq_n = SQ_ERA4;
                        else begin sq_n = SQ_IDLE; rm_n = RM_ARRAY; end
                    end
                    SQ_ERA4: begin
                        if (hit.at_b && hit.d_key2) sq_n = SQ_ERA5;
                        else begin sq_n = SQ_IDLE; rm_n = RM_ARRAY; end
                    end
                    SQ_ERA5: begin
                        sq_n = SQ_IDLE;
                        if (hit.d_sector) begin
                            if (!guarded) op_n = OP_SECT;
                        end else if (hit.d_block) begin
                            if (!guarded) op_n = OP_BLK;
                        end else if (hit.d_chip && hit.at_a) begin
                            if (wp_n) op_n = OP_CHIP;
                        end else begin
                            rm_n = RM_ARRAY;
                        end
                    end
                    default: begin
                        sq_n = SQ_IDLE;
                        rm_n = RM_ARRAY;
                    end
                endcase
            end
        end
    end

    // State registers: handshake step, read mode and pending pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q      <= SQ_IDLE;
            read_mode <= RM_ARRAY;
            op_q      <= OP_NONE;
        end else begin
            sq_q      <= sq_n;
            read_mode <= rm_n;
            op_q      <= op_n;
        end
    end

    // Target latch: captured only when an operation is launched.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_addr <= '0;
            op_data <= '0;
        end else if (op_n != OP_NONE) begin
            op_addr <= wr_addr;
            op_data <= wr_data;
        end
    end

    // Pulse decode from the registered operation.
    assign prog_start       = (op_q == OP_PROG);
    assign sect_erase_start = (op_q == OP_SECT);
    assign blk_erase_start  = (op_q == OP_BLK);
    assign chip_erase_start = (op_q == OP_CHIP);
    assign suspend_req      = (op_q == OP_SUSP);
    assign resume_req       = (op_q == OP_RES);

    logic any_pulse;
    assign any_pulse = prog_start | sect_erase_start | blk_erase_start |
                       chip_erase_start | suspend_req | resume_req;

    // R1: reset clears mode and pulses on the next clock.
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (read_mode == RM_ARRAY && !any_pulse));

    // R2: a program pulse carries the address and data of the write before it.
    p_prog_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> (op_addr == $past(wr_addr) && op_data == $past(wr_data)));

    // R8: a write while busy launches nothing but a suspend and leaves the mode alone.
    p_busy_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy) |=> (!prog_start && !sect_erase_start && !blk_erase_start &&
                             !chip_erase_start && !resume_req && $stable(read_mode)));

    // R9: chip erase never launches from a write seen with wp_n low.
    p_chip_wp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        chip_erase_start |-> $past(wp_n));

    // R9: no program launches from a protected boot-block write.
    p_prog_boot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> !($past(in_boot) && !$past(wp_n)));

    // R11: every pulse follows a host write and lasts one clock.
    p_pulse_after_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        any_pulse |-> $past(wr_en));
    p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_start || sect_erase_start || blk_erase_start || chip_erase_start) |=>
        !(prog_start || sect_erase_start || blk_erase_start || chip_erase_start));
endmodule

// File: rtl/flash_cmd_seq.sv
// Module: flash_cmd_seq (top)
// Command front end of a word-wide NOR flash model: decodes handshakes,
// keeps the read mode and provides the identification words. Assumes one
// host write per wr_en strobe and a synchronous active-low reset.
module flash_cmd_seq
    import flash_cmd_pkg::*;
#(
    parameter int          ADDR_W   = 22,
    parameter int          BLK_LSB  = 15,
    parameter bit          BOOT_TOP = 1'b0,
    parameter logic [15:0] DEV_CODE = 16'h236B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              busy,
    input  logic              wp_n,
    output logic              prog_start,
    output logic              sect_erase_start,
    output logic              blk_erase_start,
    output logic              chip_erase_start,
    output logic              suspend_req,
    output logic              resume_req,
    output logic [ADDR_W-1:0] op_addr,
    output logic [15:0]       op_data,
    output logic [1:0]        read_mode,
    output logic [15:0]       id_data
);
    localparam int IDX_W = ADDR_W - BLK_LSB;

    match_t hit;
    logic   in_boot;
    rmode_t mode;

    flash_cmd_decode u_decode (
        .low_addr (wr_addr[CMD_AW-1:0]),
        .low_data (wr_data[CMD_DW-1:0]),
        .hit      (hit)
    );

    flash_boot_guard #(.IDX_W(IDX_W), .BOOT_TOP(BOOT_TOP)) u_guard (
        .blk_idx (wr_addr[ADDR_W-1:BLK_LSB]),
        .in_boot (in_boot)
    );

    flash_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .wr_en            (wr_en),
        .wr_addr          (wr_addr),
        .wr_data          (wr_data),
        .hit              (hit),
        .in_boot          (in_boot),
        .busy             (busy),
        .wp_n             (wp_n),
        .prog_start       (prog_start),
        .sect_erase_start (sect_erase_start),
        .blk_erase_start  (blk_erase_start),
        .chip_erase_start (chip_erase_start),
        .suspend_req      (suspend_req),
        .resume_req       (resume_req),
        .op_addr          (op_addr),
        .op_data          (op_data),
        .read_mode        (mode)
    );

    assign read_mode = mode;

    // Identification words, driven only while ID mode is active.
    always_comb begin
        id_data = '0;
        if (mode == RM_ID) begin
            if (rd_addr == ADDR_W'(0))      id_data = MFR_CODE;
            else if (rd_addr == ADDR_W'(1)) id_data = DEV_CODE;
        end
    end

    // R10: outside ID mode the identification output stays zero.
    p_id_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (read_mode != 2'd1) |-> (id_data == 16'h0000));
endmodule

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
    localparam int AW = 22;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic          busy = 1'b0;
    logic          wp_n = 1'b1;
    logic          prog_start, sect_erase_start, blk_erase_start, chip_erase_start;
    logic          suspend_req, resume_req;
    logic [AW-1:0] op_addr;
    logic [15:0]   op_data;
    logic [1:0]    read_mode;
    logic [15:0]   id_data;

    int n_checks = 0;
    int n_fails  = 0;
    logic [5:0] ops_seen;

    always #2 clk = ~clk;

    flash_cmd_seq u_flash_cmd_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .busy(busy), .wp_n(wp_n),
        .prog_start(prog_start), .sect_erase_start(sect_erase_start),
        .blk_erase_start(blk_erase_start), .chip_erase_start(chip_erase_start),
        .suspend_req(suspend_req), .resume_req(resume_req),
        .op_addr(op_addr), .op_data(op_data), .read_mode(read_mode),
        .id_data(id_data)
    );

    // Pulse vector: {prog, sector, block, chip, suspend, resume}
    function automatic logic [5:0] ops_now();
        return {prog_start, sect_erase_start, blk_erase_start,
                chip_erase_start, suspend_req, resume_req};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One host write; the pulses of that write are captured one clock later.
    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        ops_seen = ops_now();
    endtask

    task automatic unlock();
        wr(22'h005555, 16'h00AA);
        wr(22'h002AAA, 16'h0055);
    endtask

    task automatic erase6(input logic [AW-1:0] a, input logic [15:0] d);
        unlock();
        wr(22'h005555, 16'h0080);
        unlock();
        wr(a, d);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        logic [1:0] exp_mode;
        logic [5:0] exp_ops;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 mode", read_mode, 0);
        check("R1 pulses", ops_now(), 0);
        check("R10 id outside", id_data, 0);
        rst_n = 1'b1;

        // R4/R10: ID mode and identification words
        unlock(); wr(22'h005555, 16'h0090);
        check("R4 id entry", read_mode, 1);
        for (int i = 0; i < 4; i++) begin
            rd_addr = AW'(i);
            #1;
            check("R10 id word", id_data, (i == 0) ? 16'h00BF : (i == 1) ? 16'h236B : 16'h0);
        end
        wr(22'h001234, 16'h00F0);
        check("R4 single exit", read_mode, 0);
        rd_addr = '0; #1;
        check("R10 id after exit", id_data, 0);

        // R1: reset mid-handshake forgets it
        unlock(); wr(22'h005555, 16'h0088);
        check("R4 secid entry", read_mode, 3);
        unlock();
        @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
        check("R1 mode after reset", read_mode, 0);
        wr(22'h005555, 16'h00A0);
        wr(22'h012345, 16'h1111);
        check("R1 no program after reset", ops_seen, 0);

        // R4/R6: sweep the third write from query mode
        for (int d = 0; d < 256; d++) begin
            unlock(); wr(22'h005555, 16'h0098);
            unlock(); wr(22'h005555, 16'(d));
            case (d)
                8'h90:        exp_mode = 1;
                8'h98:        exp_mode = 2;
                8'h88:        exp_mode = 3;
                8'hA0, 8'h80: exp_mode = 2;
                default:      exp_mode = 0;
            endcase
            check("R4 R6 third write mode", read_mode, exp_mode);
            check("R11 third write no pulse", ops_seen, 0);
            if (d == 8'hA0) begin
                wr(22'h123456, 16'hBEEF);
                check("R2 program pulse", ops_seen, 6'b100000);
                check("R2 op_addr", op_addr, 22'h123456);
                check("R2 op_data", op_data, 16'hBEEF);
                @(negedge clk);
                check("R11 single clock", ops_now(), 0);
            end else if (d == 8'h80) begin
                wr(22'h000000, 16'h0000);
                check("R6 abort in erase path", read_mode, 0);
            end
        end

        // R3/R6: sweep the sixth write
        for (int d = 0; d < 256; d++) begin
            erase6(22'h2A5555, 16'(d));
            case (d)
                8'h30:   exp_ops = 6'b010000;
                8'h50:   exp_ops = 6'b001000;
                8'h10:   exp_ops = 6'b000100;
                default: exp_ops = 6'b000000;
            endcase
            check("R3 sixth write pulse", ops_seen, exp_ops);
            if (exp_ops != 0) check("R3 op_addr", op_addr, 22'h2A5555);
        end
        erase6(22'h2A1234, 16'h0010);
        check("R3 chip needs 5555", ops_seen, 0);

        // R6: abort partway, then stray second step has no effect
        unlock(); wr(22'h005555, 16'h0090);
        wr(22'h005555, 16'h00AA); wr(22'h002AAB, 16'h0055);
        check("R6 abort mode", read_mode, 0);
        wr(22'h002AAA, 16'h0055); wr(22'h005555, 16'h0090);
        check("R6 restart needed", read_mode, 0);

        // R7: high address and data bits ignored during the handshake
        wr(22'h3F5555, 16'hC3AA); wr(22'h1AAAAA, 16'h7755); wr(22'h2DD555, 16'hFFA0);
        wr(22'h0ABCDE, 16'h5A5A);
        check("R7 program with high bits", ops_seen, 6'b100000);
        check("R7 op_data", op_data, 16'h5A5A);

        // R5: suspend and resume
        wr(22'h001357, 16'h00B0);
        check("R5 suspend", ops_seen, 6'b000010);
        wr(22'h3FFFFF, 16'h0030);
        check("R5 resume", ops_seen, 6'b000001);

        // R8: busy blocks everything but suspend
        unlock(); wr(22'h005555, 16'h0090);
        busy = 1'b1;
        wr(22'h000000, 16'h00F0);
        check("R8 exit ignored", read_mode, 1);
        unlock(); wr(22'h005555, 16'h00A0); wr(22'h100000, 16'h1234);
        check("R8 program ignored", ops_seen, 0);
        wr(22'h000000, 16'h0030);
        check("R8 resume ignored", ops_seen, 0);
        wr(22'h000000, 16'h00B0);
        check("R5 R8 suspend while busy", ops_seen, 6'b000010);
        busy = 1'b0;
        wr(22'h000000, 16'h00F0);
        check("R4 exit after busy", read_mode, 0);

        // R9: write protection of the bottom boot block
        wp_n = 1'b0;
        unlock(); wr(22'h005555, 16'h00A0); wr(22'h007FFF, 16'h0001);
        check("R9 program boot dropped", ops_seen, 0);
        unlock(); wr(22'h005555, 16'h00A0); wr(22'h008000, 16'h0002);
        check("R9 program outside boot", ops_seen, 6'b100000);
        erase6(22'h000800, 16'h0030);
        check("R9 sector boot dropped", ops_seen, 0);
        erase6(22'h004000, 16'h0050);
        check("R9 block boot dropped", ops_seen, 0);
        erase6(22'h018000, 16'h0050);
        check("R9 block outside boot", ops_seen, 6'b001000);
        erase6(22'h005555, 16'h0010);
        check("R9 chip rejected", ops_seen, 0);
        wp_n = 1'b1;
        erase6(22'h005555, 16'h0010);
        check("R9 chip allowed", ops_seen, 6'b000100);
        erase6(22'h000800, 16'h0030);
        check("R9 sector boot allowed", ops_seen, 6'b010000);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule